// File: doc/BRIEF.md
# Branch Target Cache Predictor

This block predicts, in the fetch stage, whether the instruction at the current fetch address is a taken branch and where it goes. It keeps a direct-mapped table of branches that have already been seen taken. Each entry holds an address tag, a valid flag, the last taken target and a two-bit saturating history counter. A lookup that hits the table uses the counter's upper bit for direction and the stored target for the destination.

When the table has no matching entry, a static rule decides instead. It uses the decoded branch offset for the fetched word. A backward branch (negative offset) is predicted taken and a forward one is predicted not taken. The taken target is the fetch address plus the pipeline look-ahead plus the offset scaled to bytes.

Branches are resolved later in the pipeline. The resolved outcome comes back on an update port, together with the prediction that was made for that branch. The block then trains or allocates the matching entry. In the same cycle it raises a combinational misprediction flag, which the pipeline uses to flush and refetch.

Top module: `btac_predictor`

## Requirements
- R1: While the reset is asserted, and after its synchronous release, every entry is invalid, so every lookup reports `pred_hit`=0 until an entry is allocated.
- R2: An address selects its entry with bits [8:2] (128 entries). Bits [31:9] are kept as the tag. A lookup hits only when both the index and the tag match a valid entry.
- R3: On a hit, `pred_taken` is the upper counter bit (00/01 not taken, 10/11 taken). `pred_target` is the stored target when the prediction is taken, and the fetch address plus 4 when it is not.
- R4: An update that hits an entry moves its counter one step up when the branch was taken and one step down when it was not. The counter saturates at 11 and at 00.
- R5: A taken update that misses allocates the entry at its index. It writes the tag, writes the target and sets the counter to 10.
- R6: A not-taken update that misses leaves the table unchanged.
- R7: A taken update whose tag differs from a valid entry at the same index replaces that entry. Entries are never removed in any other way.
- R8: On a miss with `lk_is_branch`=1 and `lk_offset[23]`=1, the prediction is taken and the target is lk_pc + 8 + 4*sign-extended offset. A miss with a non-negative offset, or with `lk_is_branch`=0, is predicted not taken with target lk_pc + 4.
- R9: When a lookup and an update address the same entry in one cycle, the lookup returns the entry's contents from before the update.
- R10: With `upd_valid`=1, `upd_mispredict` is 1 when `upd_taken` differs from `upd_pred_taken`. It is also 1 when both are taken and `upd_target` differs from `upd_pred_target`. It is 0 otherwise, and always 0 with `upd_valid`=0.
- R11: A taken update that hits an entry overwrites the stored target with `upd_target`. A not-taken update keeps the stored target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_pc | input | 32 | Fetch address being predicted |
| lk_is_branch | input | 1 | Decoded: fetched word is a branch (static path only) |
| lk_offset | input | 24 | Decoded signed word offset of that branch |
| pred_hit | output | 1 | Lookup matched a valid entry |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction |
| upd_target | input | 32 | Actual taken target |
| upd_pred_taken | input | 1 | Direction that was predicted for it |
| upd_pred_target | input | 32 | Target that was predicted for it |
| upd_mispredict | output | 1 | Resolved outcome disagrees with the prediction |

## Verification
One entry is walked through its whole counter range with runs of taken and not-taken updates. The runs cross both saturation points, so an unclamped or wrapping counter shows up in the predicted direction. Address pairs that share an index but differ in tag, and pairs that differ only in index, separate the tag compare from the index decode and show when allocation and conflict replacement happen. Backward, forward and non-branch misses exercise the static rule. A lookup and update on the same entry in one cycle shows whether the read returns old data, and direction and target disagreements each set the misprediction flag on their own.

// File: rtl/btac_pkg.sv
package btac_pkg;

  // Two-bit history counter states; upper bit gives the direction.
  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'b00,
    CTR_WEAK_NT   = 2'b01,
    CTR_WEAK_T    = 2'b10,
    CTR_STRONG_T  = 2'b11
  } ctr_t;

  function automatic logic ctr_says_taken(input logic [1:0] c);
    return c[1];
  endfunction

endpackage

// File: rtl/btac_rst_sync.sv
module btac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/btac_ctr_next.sv
module btac_ctr_next
  import btac_pkg::*;
(
  input  logic [1:0] cur,
  input  logic       hit,
  input  logic       taken,
  output logic [1:0] nxt
);
  always_comb begin
    if (!hit) begin
      nxt = taken ? CTR_WEAK_T : CTR_WEAK_NT;
    end else if (taken) begin
      nxt = (cur == CTR_STRONG_T) ? cur : cur + 2'd1;
    end else begin
      nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
    end
  end
endmodule

// File: rtl/btac_static.sv
module btac_static #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 24,
  parameter int ALIGN   = 2,
  parameter int LOOK_AHEAD = 8
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic              is_branch,
  input  logic [OFF_W-1:0]  offset,
  output logic              taken,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - OFF_W - ALIGN;
  localparam logic [ADDR_W-1:0] AHEAD = ADDR_W'(LOOK_AHEAD);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(1 << ALIGN);

  logic [ADDR_W-1:0] off_bytes;
  logic [ADDR_W-1:0] bwd_target;

  always_comb begin
    off_bytes  = {{EXT_W{offset[OFF_W-1]}}, offset, {ALIGN{1'b0}}};
    bwd_target = pc + AHEAD + off_bytes;
    taken      = is_branch && offset[OFF_W-1];
    target     = taken ? bwd_target : pc + STEP;
  end
endmodule

// File: rtl/btac_table.sv
module btac_table
  import btac_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 128,
  parameter int ALIGN   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_pc,
  output logic              rd_hit,
  output logic [1:0]        rd_ctr,
  output logic [ADDR_W-1:0] rd_target,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_pc,
  input  logic              wr_taken,
  input  logic [ADDR_W-1:0] wr_target
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W - ALIGN;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];
  logic [1:0]         ctr_q [ENTRIES];

  logic [IDX_W-1:0] ridx, widx;
  logic [TAG_W-1:0] rtag, wtag;
  logic             w_hit;
  logic             w_en;
  logic [1:0]       ctr_nxt;
  logic [ENTRIES-1:0] wr_sel;

  // read side: combinational, sees register contents before this edge
  always_comb begin
    ridx      = rd_pc[ALIGN +: IDX_W];
    rtag      = rd_pc[ADDR_W-1 -: TAG_W];
    rd_hit    = vld_q[ridx] && (tag_q[ridx] == rtag);
    rd_ctr    = ctr_q[ridx];
    rd_target = tgt_q[ridx];
  end

  // write side next-state
  always_comb begin
    widx  = wr_pc[ALIGN +: IDX_W];
    wtag  = wr_pc[ADDR_W-1 -: TAG_W];
    w_hit = vld_q[widx] && (tag_q[widx] == wtag);
    w_en  = wr_valid && (w_hit || wr_taken);
    for (int i = 0; i < ENTRIES; i++) begin
      wr_sel[i] = w_en && (widx == IDX_W'(i));
    end
  end

  btac_ctr_next u_ctr (
    .cur   (ctr_q[widx]),
    .hit   (w_hit),
    .taken (wr_taken),
    .nxt   (ctr_nxt)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         vld_q[g] <= 1'b0;
      else if (wr_sel[g]) vld_q[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wr_sel[g]) begin
        tag_q[g] <= wtag;
        ctr_q[g] <= ctr_nxt;
      end
      if (wr_sel[g] && wr_taken) begin
        tgt_q[g] <= wr_target;
      end
    end
  end

  // R2
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));

  // R5
  alloc_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_taken) |=>
      (vld_q[$past(widx)] && tag_q[$past(widx)] == $past(wtag)));

  // R6
  no_alloc_nt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_taken && !w_hit) |=>
      (vld_q[$past(widx)] == $past(vld_q[widx])));

  // R4
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && w_hit && wr_taken && ctr_q[widx] == CTR_STRONG_T) |=>
      (ctr_q[$past(widx)] == CTR_STRONG_T));

  // R4
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && w_hit && !wr_taken && ctr_q[widx] == CTR_STRONG_NT) |=>
      (ctr_q[$past(widx)] == CTR_STRONG_NT));

  // R11
  keep_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && w_hit && !wr_taken) |=>
      $stable(tgt_q[$past(widx)]));
endmodule

// File: rtl/btac_predictor.sv
module btac_predictor
  import btac_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 128,
  parameter int ALIGN      = 2,
  parameter int OFF_W      = 24,
  parameter int LOOK_AHEAD = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  input  logic              lk_is_branch,
  input  logic [OFF_W-1:0]  lk_offset,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_target,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              upd_pred_taken,
  input  logic [ADDR_W-1:0] upd_pred_target,
  output logic              upd_mispredict
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << ALIGN);

  logic              srst_n;
  logic              tbl_hit;
  logic [1:0]        tbl_ctr;
  logic [ADDR_W-1:0] tbl_target;
  logic              st_taken;
  logic [ADDR_W-1:0] st_target;

  btac_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  btac_table #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .ALIGN(ALIGN)) u_tbl (
    .clk       (clk),
    .rst_n     (srst_n),
    .rd_pc     (lk_pc),
    .rd_hit    (tbl_hit),
    .rd_ctr    (tbl_ctr),
    .rd_target (tbl_target),
    .wr_valid  (upd_valid),
    .wr_pc     (upd_pc),
    .wr_taken  (upd_taken),
    .wr_target (upd_target)
  );

  btac_static #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ALIGN(ALIGN),
                .LOOK_AHEAD(LOOK_AHEAD)) u_static (
    .pc        (lk_pc),
    .is_branch (lk_is_branch),
    .offset    (lk_offset),
    .taken     (st_taken),
    .target    (st_target)
  );

  always_comb begin
    pred_hit = tbl_hit;
    if (tbl_hit) begin
      pred_taken  = ctr_says_taken(tbl_ctr);
      pred_target = pred_taken ? tbl_target : lk_pc + STEP;
    end else begin
      pred_taken  = st_taken;
      pred_target = st_target;
    end
  end

  always_comb begin
    upd_mispredict = upd_valid &&
      ((upd_taken != upd_pred_taken) ||
       (upd_taken && (upd_target != upd_pred_target)));
  end

  // R8
  static_dir_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!pred_hit && lk_is_branch) |-> (pred_taken == lk_offset[OFF_W-1]));

  // R10
  mispredict_dir_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (upd_valid && (upd_taken != upd_pred_taken)) |-> upd_mispredict);

  // R10
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !upd_valid |-> !upd_mispredict);

  // R3
  nt_seq_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !pred_taken |-> (pred_target == lk_pc + STEP));
endmodule

// File: tb/sim_btac_predictor.sv
module sim_btac_predictor;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lk_pc;
  logic        lk_is_branch;
  logic [23:0] lk_offset;
  logic        pred_hit, pred_taken;
  logic [31:0] pred_target;
  logic        upd_valid, upd_taken, upd_pred_taken;
  logic [31:0] upd_pc, upd_target, upd_pred_target;
  logic        upd_mispredict;

  int total = 0;
  int bad   = 0;

  localparam logic [31:0] PA = 32'h0000_1040; // idx 0x10 tag 8
  localparam logic [31:0] PB = 32'h0000_3040; // idx 0x10 tag 0x18
  localparam logic [31:0] TA = 32'h0000_2000;
  localparam logic [31:0] TA2 = 32'h0000_2400;
  localparam logic [31:0] TB = 32'h0000_5000;

  always #(CLK_PERIOD/2) clk = ~clk;

  btac_predictor u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(lk_pc), .lk_is_branch(lk_is_branch), .lk_offset(lk_offset),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_pred_taken(upd_pred_taken),
    .upd_pred_target(upd_pred_target), .upd_mispredict(upd_mispredict)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] pc, input logic br, input logic [23:0] off,
                      input logic e_hit, input logic e_tk, input logic [31:0] e_tgt,
                      input string req);
    @(negedge clk);
    lk_pc = pc; lk_is_branch = br; lk_offset = off;
    #1;
    chk(pred_hit == e_hit, {req, " hit"}, 32'(pred_hit), 32'(e_hit));
    chk(pred_taken == e_tk, {req, " taken"}, 32'(pred_taken), 32'(e_tk));
    chk(pred_target == e_tgt, {req, " target"}, pred_target, e_tgt);
  endtask

  task automatic upd(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tgt;
    upd_pred_taken = tk; upd_pred_target = tgt;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    look(PA, 1'b0, 24'd0, 1'b0, 1'b0, PA + 4, "R1 reset empty");
    look(PB, 1'b0, 24'd0, 1'b0, 1'b0, PB + 4, "R1 reset empty");
  endtask

  task automatic t_counter();
    upd(PA, 1'b1, TA);  look(PA, 1'b0, 24'd0, 1'b1, 1'b1, TA, "R5 alloc 10");
    upd(PA, 1'b1, TA);  look(PA, 1'b0, 24'd0, 1'b1, 1'b1, TA, "R4 to 11");
    upd(PA, 1'b1, TA);  look(PA, 1'b0, 24'd0, 1'b1, 1'b1, TA, "R4 sat 11");
    upd(PA, 1'b0, 32'h0); look(PA, 1'b0, 24'd0, 1'b1, 1'b1, TA, "R4 down to 10");
    upd(PA, 1'b0, 32'h0); look(PA, 1'b0, 24'd0, 1'b1, 1'b0, PA + 4, "R3 01 not taken");
    upd(PA, 1'b0, 32'h0); look(PA, 1'b0, 24'd0, 1'b1, 1'b0, PA + 4, "R4 to 00");
    upd(PA, 1'b0, 32'h0); look(PA, 1'b0, 24'd0, 1'b1, 1'b0, PA + 4, "R4 sat 00");
    upd(PA, 1'b1, TA);  look(PA, 1'b0, 24'd0, 1'b1, 1'b0, PA + 4, "R4 up to 01");
    upd(PA, 1'b1, TA);  look(PA, 1'b0, 24'd0, 1'b1, 1'b1, TA, "R11 kept target 10");
    upd(PA, 1'b1, TA2); look(PA, 1'b0, 24'd0, 1'b1, 1'b1, TA2, "R11 new target");
  endtask

  task automatic t_conflict();
    upd(PB, 1'b0, TB);
    look(PA, 1'b0, 24'd0, 1'b1, 1'b1, TA2, "R6 entry kept");
    look(PB, 1'b0, 24'd0, 1'b0, 1'b0, PB + 4, "R6 no alloc");
    upd(PB, 1'b1, TB);
    look(PB, 1'b0, 24'd0, 1'b1, 1'b1, TB, "R7 replaced");
    look(PA, 1'b0, 24'd0, 1'b0, 1'b0, PA + 4, "R7 old evicted");
  endtask

  task automatic t_index();
    upd(32'h0000_0204, 1'b1, 32'h0000_0900);
    look(32'h0000_0204, 1'b0, 24'd0, 1'b1, 1'b1, 32'h0000_0900, "R2 own hit");
    look(32'h0000_0004, 1'b0, 24'd0, 1'b0, 1'b0, 32'h0000_0008, "R2 tag differs");
    look(32'h0000_0208, 1'b0, 24'd0, 1'b0, 1'b0, 32'h0000_020C, "R2 index differs");
  endtask

  task automatic t_static();
    look(32'h0000_8000, 1'b1, 24'hFFFFFE, 1'b0, 1'b1, 32'h0000_8000, "R8 backward");
    look(32'h0000_8000, 1'b1, 24'hFFFF00, 1'b0, 1'b1, 32'h0000_7C08, "R8 backward far");
    look(32'h0000_8000, 1'b1, 24'h000010, 1'b0, 1'b0, 32'h0000_8004, "R8 forward");
    look(32'h0000_8000, 1'b0, 24'hFFFFFE, 1'b0, 1'b0, 32'h0000_8004, "R8 not branch");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    lk_pc = 32'h0000_6100; lk_is_branch = 1'b0; lk_offset = 24'd0;
    upd_valid = 1'b1; upd_pc = 32'h0000_6100; upd_taken = 1'b1;
    upd_target = 32'h0000_6800; upd_pred_taken = 1'b1; upd_pred_target = 32'h0000_6800;
    #1;
    chk(pred_hit == 1'b0, "R9 old contents hit", 32'(pred_hit), 32'd0);
    chk(pred_target == 32'h0000_6104, "R9 old contents target", pred_target, 32'h0000_6104);
    @(negedge clk);
    upd_valid = 1'b0;
    #1;
    chk(pred_hit == 1'b1, "R9 after edge hit", 32'(pred_hit), 32'd1);
    chk(pred_target == 32'h0000_6800, "R9 after edge target", pred_target, 32'h0000_6800);
  endtask

  task automatic mp(input logic v, input logic tk, input logic ptk,
                    input logic [31:0] tgt, input logic [31:0] ptgt,
                    input logic e, input string req);
    @(negedge clk);
    upd_valid = v; upd_pc = 32'h0000_7000; upd_taken = tk; upd_target = tgt;
    upd_pred_taken = ptk; upd_pred_target = ptgt;
    #1;
    chk(upd_mispredict == e, req, 32'(upd_mispredict), 32'(e));
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic t_mispredict();
    mp(1'b1, 1'b1, 1'b0, 32'h100, 32'h100, 1'b1, "R10 dir taken");
    mp(1'b1, 1'b0, 1'b1, 32'h100, 32'h100, 1'b1, "R10 dir not taken");
    mp(1'b1, 1'b0, 1'b0, 32'h100, 32'h200, 1'b0, "R10 both nt");
    mp(1'b1, 1'b1, 1'b1, 32'h100, 32'h100, 1'b0, "R10 match");
    mp(1'b1, 1'b1, 1'b1, 32'h100, 32'h104, 1'b1, "R10 target");
    mp(1'b0, 1'b1, 1'b0, 32'h100, 32'h104, 1'b0, "R10 idle");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    lk_pc = '0; lk_is_branch = 1'b0; lk_offset = '0;
    upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0; upd_target = '0;
    upd_pred_taken = 1'b0; upd_pred_target = '0;
    t_reset();
    t_counter();
    t_conflict();
    t_index();
    t_static();
    t_same_cycle();
    t_mispredict();
    do_reset();
    look(PB, 1'b0, 24'd0, 1'b0, 1'b0, PB + 4, "R1 re-reset clears");
    look(32'h0000_6100, 1'b0, 24'd0, 1'b0, 1'b0, 32'h0000_6104, "R1 re-reset clears");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule